// File: doc/BRIEF.md
# SCSI DMA Transfer Counter Unit

This unit keeps the byte count of a DMA data transfer for a SCSI protocol controller and drives the controller's DMA request line. Software writes a start count through byte-wide registers at small offsets. A DMA-type command with its enable bit set (the `cmd_load` pulse) copies that start count into a working down-counter. Each data handshake then decrements the counter. When the count runs out, the terminal-count flag `tc0` rises.

The counter is 16 bits wide by default. A feature-enable bit in configuration register 2 widens it to 24 bits. While that bit is clear, the top count register reads back a fixed identification byte. The DMA request depends on the transfer direction, the FIFO occupancy, the synchronous offset, the terminal count and a save-last-byte bit in configuration register 3. With these inputs the controller can keep a final byte for the processor instead of moving it to memory.

A small state machine tracks the counter:
- `CNT_IDLE` is the state after reset.
- `CNT_IDLE` goes to `CNT_RUN` on a load.
- `CNT_IDLE` goes to `CNT_TERM` on a decrement at zero.
- `CNT_RUN` goes to `CNT_TERM` when a decrement reaches or sits at zero.
- `CNT_RUN` stays in `CNT_RUN` on a reload.
- `CNT_TERM` goes to `CNT_RUN` on a load.

`tc0` is high exactly in `CNT_TERM`.

Top module: `scsi_xfer_count_unit`

## Requirements
- R1: The working counter is limited to 16 bits while bit 6 of configuration register 2 (offset 11) is clear, and to 24 bits while it is set. A write to offset 11 applies the new limit to the counter in the same clock.
- R2: A write to offset 14 replaces bits 23:16 of the start count and leaves bits 15:0 unchanged.
- R3: A read of offset 14 returns counter bits 23:16 when the feature bit is set. Otherwise it returns the identification byte 8'h12, which is family code 2 in bits 7:3 and revision 2 in bits 2:0.
- R4: Offsets 11, 12 and 13 (configuration registers 2, 3 and 4) are plain read/write bytes that reset to zero. Unmapped offsets read zero.
- R5: A decrement lowers a nonzero counter by one. A decrement that leaves the counter at zero sets `tc0`. A decrement at zero keeps the counter at zero.
- R6: The decrement strobe is `sack_strobe` when all three of these hold: `initiator_mode` is 1, `sync_offset` is 0 and `bus_phase` is 3'b001 (data in). In every other case the strobe is `dack_strobe`, and the unselected strobe has no effect.
- R7: In a device-to-memory DMA (`dma_to_mem`=1) with `sync_offset`=0, `drq` is asserted when the FIFO count is greater than 1 if either bit 2 of configuration register 3 is set or `tc0` is clear. Otherwise it is asserted when the FIFO count is greater than 0.
- R8: In a device-to-memory DMA with a nonzero `sync_offset`, `drq` is asserted only when `tc0` is clear and the FIFO count is greater than 1.
- R9: In a memory-to-device DMA, `drq` is asserted while `tc0` is clear and the FIFO count is below the FIFO depth (16). With `dma_active`=0, `drq` is low.
- R10: A `cmd_load` pulse copies the start count, limited by the current width, into the counter and clears `tc0`. A load takes priority over a decrement in the same clock.
- R11: Offsets 0 and 1 write bits 7:0 and 15:8 of the start count, and read bits 7:0 and 15:8 of the working counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cmd_load | input | 1 | DMA command with enable: load the counter |
| dma_active | input | 1 | A DMA command is in progress |
| dma_to_mem | input | 1 | 1 = device to memory, 0 = memory to device |
| dack_strobe | input | 1 | DMA acknowledge handshake pulse |
| sack_strobe | input | 1 | SCSI acknowledge handshake pulse |
| initiator_mode | input | 1 | Controller acts as initiator |
| sync_offset | input | 4 | Synchronous offset, 0 = asynchronous |
| bus_phase | input | 3 | SCSI bus phase, 3'b001 = data in |
| fifo_count | input | 5 | Bytes held in the FIFO |
| drq | output | 1 | DMA request |
| tc0 | output | 1 | Terminal count reached |

## Verification
On every cycle the assertions check the following:
- the 16-bit limit while the feature bit is clear;
- that `tc0` clears after a load, sets when the count reaches zero, and that the counter stays at zero when decremented there;
- that the upper start byte write leaves the lower start bytes alone;
- the identification readback;
- that the unselected strobe has no effect;
- the three `drq` hold-back rules.

Only the bench scenarios can show the following:
- the exact readback values after mixed register writes;
- truncation of a wide count when the feature bit drops;
- the full `drq` table over FIFO counts from empty to full for every mix of direction, offset, save bit and terminal count.

The bench compares each of these against a behavioural model on every clock.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    localparam int CNT_W  = 24;
    localparam int BASE_W = 16;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_TERM = 2'd2
    } cnt_state_e;

    localparam logic [3:0] ADDR_CNT_LO  = 4'd0;
    localparam logic [3:0] ADDR_CNT_MID = 4'd1;
    localparam logic [3:0] ADDR_CFG2    = 4'd11;
    localparam logic [3:0] ADDR_CFG3    = 4'd12;
    localparam logic [3:0] ADDR_CFG4    = 4'd13;
    localparam logic [3:0] ADDR_CNT_HI  = 4'd14;

    localparam int FE_BIT   = 6;
    localparam int SAVE_BIT = 2;

    localparam logic [4:0] FAMILY_CODE = 5'd2;
    localparam logic [2:0] REVISION    = 3'd2;
    localparam logic [7:0] ID_BYTE     = {FAMILY_CODE, REVISION};

    localparam logic [2:0] PHASE_DATA_IN = 3'b001;
endpackage

// File: rtl/xfc_regs.sv
module xfc_regs
    import xfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             wr,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       rdata,
    output logic [CNT_W-1:0] start_cnt,
    output logic             fe_now,
    output logic             save_last
);
    localparam int NBYTES = CNT_W / 8;

    logic [7:0] cfg2_q, cfg3_q, cfg4_q;

    function automatic logic [3:0] start_addr(input int b);
        return (b == NBYTES - 1) ? ADDR_CNT_HI : 4'(b);
    endfunction

    for (genvar b = 0; b < NBYTES; b++) begin : g_start
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                start_cnt[b*8 +: 8] <= '0;
            else if (wr && addr == start_addr(b))
                start_cnt[b*8 +: 8] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg2_q <= '0;
            cfg3_q <= '0;
            cfg4_q <= '0;
        end else if (wr) begin
            if (addr == ADDR_CFG2) cfg2_q <= wdata;
            if (addr == ADDR_CFG3) cfg3_q <= wdata;
            if (addr == ADDR_CFG4) cfg4_q <= wdata;
        end
    end

    // The new limit takes effect in the same clock as the configuration write.
    assign fe_now    = (wr && addr == ADDR_CFG2) ? wdata[FE_BIT] : cfg2_q[FE_BIT];
    assign save_last = cfg3_q[SAVE_BIT];

    always_comb begin
        case (addr)
            ADDR_CNT_LO:  rdata = cnt[7:0];
            ADDR_CNT_MID: rdata = cnt[15:8];
            ADDR_CFG2:    rdata = cfg2_q;
            ADDR_CFG3:    rdata = cfg3_q;
            ADDR_CFG4:    rdata = cfg4_q;
            ADDR_CNT_HI:  rdata = cfg2_q[FE_BIT] ? cnt[23:16] : ID_BYTE;
            default:      rdata = 8'h00;
        endcase
    end

    AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CNT_HI) |=> $stable(start_cnt[15:0])); // R2
    AST_ID_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_CNT_HI && !cfg2_q[FE_BIT]) |-> (rdata == 8'h12)); // R3
    AST_CFG4_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CFG4) |=> (cfg4_q == $past(wdata))); // R4
    AST_LOW_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CNT_LO) |=> (start_cnt[7:0] == $past(wdata))); // R11
endmodule

// File: rtl/xfc_counter.sv
module xfc_counter
    import xfc_pkg::*;
#(
    parameter int SYNC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dec_dack,
    input  logic              dec_sack,
    input  logic              initiator,
    input  logic [SYNC_W-1:0] sync_offset,
    input  logic [2:0]        phase,
    input  logic              fe_now,
    input  logic [CNT_W-1:0]  start_cnt,
    output logic [CNT_W-1:0]  cnt,
    output logic              tc0
);
    localparam logic [CNT_W-1:0] MASK_NARROW = {{(CNT_W-BASE_W){1'b0}}, {BASE_W{1'b1}}};

    cnt_state_e       state_q, state_d;
    logic             use_sack, dec_fire, reach_zero;
    logic [CNT_W-1:0] mask, cnt_d;

    always_comb begin
        use_sack   = initiator && (sync_offset == '0) && (phase == PHASE_DATA_IN);
        dec_fire   = use_sack ? dec_sack : dec_dack;
        mask       = fe_now ? '1 : MASK_NARROW;
        reach_zero = !load && dec_fire && (cnt <= CNT_W'(1));
        if (load)
            cnt_d = start_cnt & mask;
        else if (dec_fire && cnt != '0)
            cnt_d = (cnt - CNT_W'(1)) & mask;
        else
            cnt_d = cnt & mask;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (load) state_d = CNT_RUN; else if (reach_zero) state_d = CNT_TERM;
            CNT_RUN:  if (load) state_d = CNT_RUN; else if (reach_zero) state_d = CNT_TERM;
            CNT_TERM: if (load) state_d = CNT_RUN;
            default:  state_d = CNT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    always_comb tc0 = (state_q == CNT_TERM);

    AST_NARROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_now |=> (cnt[CNT_W-1:BASE_W] == '0)); // R1
    AST_ZERO_SETS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec_fire && cnt == CNT_W'(1)) |=> (tc0 && cnt == '0)); // R5
    AST_FLOOR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec_fire && cnt == '0) |=> (cnt == '0 && tc0)); // R5
    AST_OTHER_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && use_sack && !dec_sack && cnt[CNT_W-1:BASE_W] == '0) |=> $stable(cnt)); // R6
    AST_LOAD_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tc0); // R10
endmodule

// File: rtl/xfc_drq.sv
module xfc_drq #(
    parameter int FIFO_DEPTH = 16,
    parameter int SYNC_W     = 4,
    localparam int FIFO_CW   = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_active,
    input  logic               to_mem,
    input  logic [SYNC_W-1:0]  sync_offset,
    input  logic               tc0,
    input  logic               save_last,
    input  logic [FIFO_CW-1:0] fifo_count,
    output logic               drq
);
    logic [FIFO_CW-1:0] keep_back;

    always_comb begin
        keep_back = (save_last || !tc0) ? FIFO_CW'(1) : FIFO_CW'(0);
        if (!dma_active)
            drq = 1'b0;
        else if (to_mem) begin
            if (sync_offset == '0)
                drq = fifo_count > keep_back;
            else
                drq = !tc0 && (fifo_count > FIFO_CW'(1));
        end else
            drq = !tc0 && (fifo_count < FIFO_CW'(FIFO_DEPTH));
    end

    AST_ASYNC_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_active && to_mem && sync_offset == '0 && fifo_count == FIFO_CW'(1)
         && (save_last || !tc0)) |-> !drq); // R7
    AST_SYNC_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_active && to_mem && sync_offset != '0 && tc0) |-> !drq); // R8
    AST_DRQ_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_active |-> !drq); // R9
endmodule

// File: rtl/scsi_xfer_count_unit.sv
module scsi_xfer_count_unit
    import xfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int SYNC_W     = 4,
    localparam int FIFO_CW   = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_wr,
    output logic [7:0]         reg_rdata,
    input  logic               cmd_load,
    input  logic               dma_active,
    input  logic               dma_to_mem,
    input  logic               dack_strobe,
    input  logic               sack_strobe,
    input  logic               initiator_mode,
    input  logic [SYNC_W-1:0]  sync_offset,
    input  logic [2:0]         bus_phase,
    input  logic [FIFO_CW-1:0] fifo_count,
    output logic               drq,
    output logic               tc0
);
    logic [CNT_W-1:0] cnt, start_cnt;
    logic             fe_now, save_last;

    xfc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .wr        (reg_wr),
        .cnt       (cnt),
        .rdata     (reg_rdata),
        .start_cnt (start_cnt),
        .fe_now    (fe_now),
        .save_last (save_last)
    );

    xfc_counter #(.SYNC_W(SYNC_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cmd_load),
        .dec_dack    (dack_strobe),
        .dec_sack    (sack_strobe),
        .initiator   (initiator_mode),
        .sync_offset (sync_offset),
        .phase       (bus_phase),
        .fe_now      (fe_now),
        .start_cnt   (start_cnt),
        .cnt         (cnt),
        .tc0         (tc0)
    );

    xfc_drq #(.FIFO_DEPTH(FIFO_DEPTH), .SYNC_W(SYNC_W)) u_drq (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_active  (dma_active),
        .to_mem      (dma_to_mem),
        .sync_offset (sync_offset),
        .tc0         (tc0),
        .save_last   (save_last),
        .fifo_count  (fifo_count),
        .drq         (drq)
    );
endmodule

// File: tb/scsi_xfer_count_unit_tb.sv
module scsi_xfer_count_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic       reg_wr = 0, cmd_load = 0, dma_active = 0, dma_to_mem = 0;
    logic       dack_strobe = 0, sack_strobe = 0, initiator_mode = 0;
    logic [3:0] sync_offset = 0;
    logic [2:0] bus_phase = 0;
    logic [4:0] fifo_count = 0;
    logic [7:0] reg_rdata;
    logic       drq, tc0;

    int    n_checks = 0, n_fail = 0;
    string cur_req = "R4";
    bit    finished = 0;

    scsi_xfer_count_unit dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_start = 0, m_cnt = 0, m_cfg2 = 0, m_cfg3 = 0, m_cfg4 = 0;
    bit m_tc0 = 0;
    int lim;
    bit use_s, strobe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_start = 0; m_cnt = 0; m_cfg2 = 0; m_cfg3 = 0; m_cfg4 = 0; m_tc0 = 0;
        end else begin
            if (reg_wr && reg_addr == 11) lim = reg_wdata[6] ? 'hFFFFFF : 'hFFFF;
            else lim = m_cfg2[6] ? 'hFFFFFF : 'hFFFF;
            use_s  = initiator_mode && sync_offset == 0 && bus_phase == 3'b001;
            strobe = use_s ? sack_strobe : dack_strobe;
            if (cmd_load) begin
                m_cnt = m_start & lim; m_tc0 = 0;
            end else begin
                if (strobe) begin
                    if (m_cnt > 0) m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_tc0 = 1;
                end
                m_cnt = m_cnt & lim;
            end
            if (reg_wr) begin
                case (reg_addr)
                    0:  m_start = (m_start & 'hFFFF00) | reg_wdata;
                    1:  m_start = (m_start & 'hFF00FF) | (int'(reg_wdata) << 8);
                    14: m_start = (m_start & 'h00FFFF) | (int'(reg_wdata) << 16);
                    11: m_cfg2 = reg_wdata;
                    12: m_cfg3 = reg_wdata;
                    13: m_cfg4 = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit exp_drq();
        int thr;
        if (!dma_active) return 0;
        if (dma_to_mem) begin
            if (sync_offset == 0) begin
                thr = (m_cfg3[2] || !m_tc0) ? 1 : 0;
                return int'(fifo_count) > thr;
            end
            return !m_tc0 && fifo_count > 1;
        end
        return !m_tc0 && fifo_count < 16;
    endfunction

    function automatic logic [7:0] exp_rdata();
        case (reg_addr)
            0:  return 8'(m_cnt);
            1:  return 8'(m_cnt >> 8);
            11: return 8'(m_cfg2);
            12: return 8'(m_cfg3);
            13: return 8'(m_cfg4);
            14: return m_cfg2[6] ? 8'(m_cnt >> 16) : 8'h12;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (!finished) begin
        check(drq === exp_drq(), "drq", drq, exp_drq());
        check(tc0 === m_tc0, "tc0", tc0, m_tc0);
        check(reg_rdata === exp_rdata(), "rdata", reg_rdata, exp_rdata());
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        reg_addr = a; tick();
    endtask

    task automatic load();
        cmd_load = 1; tick(); cmd_load = 0;
    endtask

    task automatic pulse(input bit use_sack);
        if (use_sack) sack_strobe = 1; else dack_strobe = 1;
        tick();
        sack_strobe = 0; dack_strobe = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // reset state: R4, R3 readback of ID
        tick(3);
        rst_n = 1;
        cur_req = "R4";
        for (int a = 0; a < 16; a++) rd(4'(a));
        wr(13, 8'hA5); wr(12, 8'h3C); rd(13); rd(12); rd(9);
        cur_req = "R3"; rd(14);

        // R11, R1: start bytes, narrow load
        cur_req = "R11";
        wr(0, 8'h02); wr(1, 8'h05); wr(14, 8'h03);
        load(); rd(0); rd(1);
        cur_req = "R1"; rd(14);

        // R2: upper byte write keeps low bytes; wide load
        cur_req = "R2";
        wr(14, 8'h7E);
        wr(11, 8'h40); load(); rd(14); rd(0); rd(1);
        cur_req = "R3"; rd(14);
        // R1: dropping the feature bit truncates at once
        cur_req = "R1";
        wr(11, 8'h00); rd(14); rd(1); rd(0);

        // R5: count down through zero
        cur_req = "R5";
        wr(0, 8'h03); wr(1, 8'h00);
        cur_req = "R10"; load(); rd(0);
        cur_req = "R5";
        dma_active = 1;
        for (int i = 0; i < 5; i++) pulse(0);
        rd(0);
        cur_req = "R10"; load(); rd(0);

        // R6: strobe selection
        cur_req = "R6";
        initiator_mode = 1; sync_offset = 0; bus_phase = 3'b001;
        pulse(0); pulse(0); rd(0);
        pulse(1); rd(0);
        bus_phase = 3'b000; pulse(1); pulse(0); rd(0);
        bus_phase = 3'b001; sync_offset = 4'd2; pulse(1); pulse(0); rd(0);
        initiator_mode = 0; sync_offset = 0; pulse(1); pulse(0); rd(0);
        // R10: load and decrement in the same clock
        cur_req = "R10";
        wr(0, 8'h09); cmd_load = 1; dack_strobe = 1; tick();
        cmd_load = 0; dack_strobe = 0; rd(0);

        // R7, R8, R9: drq table
        for (int dir = 0; dir < 2; dir++)
            for (int so = 0; so < 2; so++)
                for (int sv = 0; sv < 2; sv++)
                    for (int tc = 0; tc < 2; tc++) begin
                        dma_active = 0;
                        wr(12, sv ? 8'h04 : 8'h00);
                        wr(0, tc ? 8'h01 : 8'h40);
                        load();
                        if (tc) pulse(0);
                        dma_active = 1; dma_to_mem = dir[0];
                        sync_offset = so ? 4'd5 : 4'd0;
                        cur_req = !dir ? "R9" : (so ? "R8" : "R7");
                        for (int f = 0; f <= 16; f++) begin
                            fifo_count = 5'(f); tick();
                        end
                        fifo_count = 0;
                    end
        cur_req = "R9"; dma_active = 0; fifo_count = 3; tick(2);

        tick();
        finished = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule